// File: doc/BRIEF.md
# Serial Transceiver Bring-Up Sequencer

This block brings a multi-gigabit serial transceiver out of reset without software. After reset it drives a simple memory-mapped bus as its master. It holds the lanes in reset for a settling window, then writes a small constant table of configuration registers. The table sets the clock multiplier and dividers, the line rate, the reference clock selection and the lane termination. It then marks initialization complete and pulses the receiver reset. Next it steps the clock-data-recovery circuit through its lock stages one at a time, and each stage is held for a minimum time. It then enters a polling loop that reads a status register and drives the status outputs from the value read.

The four lanes share one reset signal, so all lane-reset bits always carry the same value. Each bus transfer has a one-cycle setup phase followed by an access phase that lasts until the target asserts ready, so slow register targets are tolerated.

Top module: `serdes_init_seq`

## Requirements
- R1: While `rst` is high, `psel`, `penable`, `init_done`, `rx_locked` and `status_word` are 0 and every bit of `lane_rst` is 1.
- R2: Every transfer starts with one setup cycle (`psel`=1, `penable`=0). The access phase follows (`penable`=1), and `paddr`, `pwdata` and `pwrite` stay stable until a cycle with `pready`=1 ends the transfer. `penable` is never high without `psel`.
- R3: The first six transfers after reset are writes with `paddr` = 4·i for i = 0..5, in increasing i. The data are 0x1 (reference clock select), 0x14 (feedback divider N=20), 0x1 (input divider M=1), 0x2 (output divider F=2), 0x12C0 (line rate 4800 Mb/s) and 0x32 (50-ohm termination).
- R4: All `lane_rst` bits are always equal. They are 1 from reset through the settling window, 0 during the table writes, and 1 again for the receiver reset after `init_done` rises. They are 0 before the first lock-step write. No transfer happens while they are 1.
- R5: `init_done` is 0 while the table writes complete. It is 1 before the first lock-step write and stays 1 until the next reset.
- R6: Transfers 6, 7 and 8 are writes of the values 1 (frequency lock), 2 (coarse phase) and 3 (fine phase) to address 0x40, in that order.
- R7: After each lock-step write completes, the next transfer does not start until at least `HOLD_CYCLES` cycles later.
- R8: From transfer 9 on, every transfer is a read of address 0x44. Each read starts at least `POLL_CYCLES` cycles after the previous read completes, and the reads repeat indefinitely.
- R9: Within three cycles after a status read completes, `status_word` equals the data read and `rx_locked` equals bit 0 of it.
- R10: A reset in the middle of the sequence clears `init_done` and restarts the sequence from table entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paddr | output | ADDR_W | Bus address |
| pwdata | output | DATA_W | Bus write data |
| prdata | input | DATA_W | Bus read data |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus access phase |
| pwrite | output | 1 | Bus direction, 1 = write |
| pready | input | 1 | Target ready, ends the access phase |
| lane_rst | output | NUM_LANES | Lane resets, one common value |
| init_done | output | 1 | Register table loaded |
| rx_locked | output | 1 | Bit 0 of the last status read |
| status_word | output | DATA_W | Last status read value |

## Verification
The hardest situations to reach from the ports are the timing windows: the lock-step hold and the poll spacing must be measured while the bus target stretches each access, and a reset must land while a table write is still in flight. The bench acts as the bus target. It sweeps the wait states from zero to three over whole bring-up runs and times the gap from each completion to the next setup cycle. It also issues a second reset after a counted number of table writes and checks that the transfer sequence starts again from entry 0.

// File: rtl/serdes_init_pkg.sv
package serdes_init_pkg;

  localparam int TBL_DEPTH = 6;
  localparam logic [15:0] CDR_CTRL_ADDR = 16'h0040;
  localparam logic [15:0] STATUS_ADDR   = 16'h0044;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RESET, ST_INIT, ST_DONE, ST_RXRST,
    ST_FREQ, ST_COARSE, ST_FINE, ST_REFRESH
  } seq_state_t;

  typedef struct packed {
    logic [15:0] addr;
    logic [31:0] data;
  } reg_wr_t;

  // Configuration table: address is 4 * index
  function automatic reg_wr_t table_entry(input int unsigned idx);
    reg_wr_t e;
    e.addr = 16'(idx * 4);
    case (idx)
      0:       e.data = 32'h0000_0001; // reference clock drives the SERDES clock
      1:       e.data = 32'h0000_0014; // N = 20
      2:       e.data = 32'h0000_0001; // M = 1
      3:       e.data = 32'h0000_0002; // F = 2
      4:       e.data = 32'h0000_12C0; // 4800 Mb/s
      default: e.data = 32'h0000_0032; // 50 ohm
    endcase
    return e;
  endfunction

  function automatic logic [31:0] step_code(input seq_state_t s);
    case (s)
      ST_FREQ:   return 32'd1;
      ST_COARSE: return 32'd2;
      default:   return 32'd3;
    endcase
  endfunction

  function automatic seq_state_t step_next(input seq_state_t s);
    case (s)
      ST_FREQ:   return ST_COARSE;
      ST_COARSE: return ST_FINE;
      default:   return ST_REFRESH;
    endcase
  endfunction

endpackage

// File: rtl/apb_xfer.sv
module apb_xfer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      psel    <= 1'b0;
      penable <= 1'b0;
      pwrite  <= 1'b0;
      paddr   <= '0;
      pwdata  <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!psel) begin
        if (start) begin
          psel   <= 1'b1;
          pwrite <= wr;
          paddr  <= addr;
          pwdata <= wdata;
        end
      end else if (!penable) begin
        penable <= 1'b1;
      end else if (pready) begin
        psel    <= 1'b0;
        penable <= 1'b0;
        done    <= 1'b1;
        rdata   <= prdata;
      end
    end
  end

  p_enable_needs_sel_r2: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);
  p_setup_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(penable) |-> $past(psel && !penable));
  p_hold_on_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwdata) && $stable(pwrite)));

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= len;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/serdes_init_seq.sv
module serdes_init_seq
  import serdes_init_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_LANES   = 4,
  parameter int HOLD_CYCLES = 1024,
  parameter int POLL_CYCLES = 4096
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [ADDR_W-1:0]    paddr,
  output logic [DATA_W-1:0]    pwdata,
  input  logic [DATA_W-1:0]    prdata,
  output logic                 psel,
  output logic                 penable,
  output logic                 pwrite,
  input  logic                 pready,
  output logic [NUM_LANES-1:0] lane_rst,
  output logic                 init_done,
  output logic                 rx_locked,
  output logic [DATA_W-1:0]    status_word
);

  localparam int TMR_MAX = (HOLD_CYCLES > POLL_CYCLES) ? HOLD_CYCLES : POLL_CYCLES;
  localparam int CNT_W   = $clog2(TMR_MAX + 1);
  localparam int IDX_W   = $clog2(TBL_DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_DEPTH - 1);

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pend_q, hold_q, lrst_q, done_q, locked_q;
  logic              start_q, wr_q, tload_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, status_q;
  logic [CNT_W-1:0]  tlen_q;
  logic              xfer_done, tmr_exp, hold_over;
  logic [DATA_W-1:0] xfer_rdata;
  reg_wr_t           entry;

  assign entry     = table_entry(int'(idx_q));
  assign hold_over = hold_q && tmr_exp && !tload_q;

  apb_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .start(start_q), .wr(wr_q), .addr(addr_q),
    .wdata(wdata_q), .done(xfer_done), .rdata(xfer_rdata),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pready(pready), .prdata(prdata)
  );

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tload_q), .len(tlen_q), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      pend_q   <= 1'b0;
      hold_q   <= 1'b0;
      lrst_q   <= 1'b1;
      done_q   <= 1'b0;
      locked_q <= 1'b0;
      status_q <= '0;
      start_q  <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      tload_q  <= 1'b0;
      tlen_q   <= '0;
    end else begin
      start_q <= 1'b0;
      tload_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          lrst_q  <= 1'b1;
          hold_q  <= 1'b1;
          tload_q <= 1'b1;
          tlen_q  <= CNT_W'(HOLD_CYCLES);
          state_q <= ST_RESET;
        end
        ST_RESET: if (hold_over) begin
          hold_q  <= 1'b0;
          lrst_q  <= 1'b0;
          idx_q   <= '0;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          if (!pend_q) begin
            start_q <= 1'b1;
            wr_q    <= 1'b1;
            addr_q  <= ADDR_W'(entry.addr);
            wdata_q <= DATA_W'(entry.data);
            pend_q  <= 1'b1;
          end else if (xfer_done) begin
            pend_q <= 1'b0;
            if (idx_q == LAST_IDX) state_q <= ST_DONE;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          lrst_q  <= 1'b1;
          hold_q  <= 1'b1;
          tload_q <= 1'b1;
          tlen_q  <= CNT_W'(HOLD_CYCLES);
          state_q <= ST_RXRST;
        end
        ST_RXRST: if (hold_over) begin
          hold_q  <= 1'b0;
          lrst_q  <= 1'b0;
          state_q <= ST_FREQ;
        end
        ST_FREQ, ST_COARSE, ST_FINE: begin
          if (!pend_q && !hold_q) begin
            start_q <= 1'b1;
            wr_q    <= 1'b1;
            addr_q  <= ADDR_W'(CDR_CTRL_ADDR);
            wdata_q <= DATA_W'(step_code(state_q));
            pend_q  <= 1'b1;
          end else if (pend_q && xfer_done) begin
            pend_q  <= 1'b0;
            hold_q  <= 1'b1;
            tload_q <= 1'b1;
            tlen_q  <= CNT_W'(HOLD_CYCLES);
          end else if (hold_over) begin
            hold_q  <= 1'b0;
            state_q <= step_next(state_q);
          end
        end
        default: begin
          if (!pend_q && !hold_q) begin
            start_q <= 1'b1;
            wr_q    <= 1'b0;
            addr_q  <= ADDR_W'(STATUS_ADDR);
            wdata_q <= '0;
            pend_q  <= 1'b1;
          end else if (pend_q && xfer_done) begin
            pend_q   <= 1'b0;
            hold_q   <= 1'b1;
            tload_q  <= 1'b1;
            tlen_q   <= CNT_W'(POLL_CYCLES);
            status_q <= xfer_rdata;
            locked_q <= xfer_rdata[0];
          end else if (hold_over) begin
            hold_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // One register fans out to every lane
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_rst[g] = lrst_q;
  end

  assign init_done   = done_q;
  assign rx_locked   = locked_q;
  assign status_word = status_q;

  p_no_xfer_in_reset_r4: assert property (@(posedge clk) disable iff (rst)
    psel |-> !lrst_q);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  p_step_after_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_COARSE || state_q == ST_FINE || state_q == ST_REFRESH) &&
     state_q != $past(state_q)) |-> $past(tmr_exp));
  p_status_from_read_r9: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_done && state_q == ST_REFRESH) |-> (status_word == xfer_rdata));

endmodule

// File: tb/tb_serdes_init_seq.sv
module tb_serdes_init_seq;

  localparam int HOLD = 16;
  localparam int POLL = 32;
  localparam int NL   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   paddr;
  logic [31:0]   pwdata, prdata, status_word;
  logic          psel, penable, pwrite, pready, init_done, rx_locked;
  logic [NL-1:0] lane_rst;

  int checks = 0, fails = 0, cyc = 0;
  int k = 0, comp_cyc = 0, acc = 0, ws = 0, stat_cd = 0, reads = 0;
  logic saw_rxrst = 1'b0, finished = 1'b0;
  logic [31:0] last_rd = '0;

  serdes_init_seq #(.ADDR_W(16), .DATA_W(32), .NUM_LANES(NL),
                    .HOLD_CYCLES(HOLD), .POLL_CYCLES(POLL)) dut (
    .clk(clk), .rst(rst), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .psel(psel), .penable(penable), .pwrite(pwrite), .pready(pready),
    .lane_rst(lane_rst), .init_done(init_done), .rx_locked(rx_locked),
    .status_word(status_word));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] tbl_data(input int i);
    case (i)
      0: return 32'h1;   1: return 32'h14;  2: return 32'h1;
      3: return 32'h2;   4: return 32'h12C0; default: return 32'h32;
    endcase
  endfunction

  function automatic logic [31:0] rd_val(input int n);
    return 32'h5A00_0000 | 32'(n << 4) | 32'(n & 1);
  endfunction

  // Bus target and transfer monitor
  always @(negedge clk) begin
    if (rst) begin
      k = 0; acc = 0; pready = 1'b0; prdata = '0; stat_cd = 0; reads = 0;
      saw_rxrst = 1'b0; comp_cyc = cyc;
    end else begin
      chk(lane_rst == '0 || lane_rst == '1, "R4 lanes equal", 32'(lane_rst), 32'h0);
      if (psel && lane_rst != '0) chk(1'b0, "R4 transfer during lane reset", 32'(lane_rst), 32'h0);
      if (init_done && lane_rst != '0) saw_rxrst = 1'b1;
      if (stat_cd > 0) begin
        stat_cd--;
        if (stat_cd == 0) begin
          chk(status_word == last_rd, "R9 status_word", status_word, last_rd);
          chk(rx_locked == last_rd[0], "R9 rx_locked", 32'(rx_locked), 32'(last_rd[0]));
        end
      end
      if (psel && !penable) begin
        if (k == 6) begin
          chk(init_done, "R5 done before lock steps", 32'(init_done), 32'h1);
          chk(saw_rxrst, "R4 receiver reset pulse", 32'(saw_rxrst), 32'h1);
        end
        if (k >= 7 && k <= 9)
          chk(cyc - comp_cyc >= HOLD && cyc - comp_cyc <= HOLD + 8, "R7 hold gap",
              32'(cyc - comp_cyc), 32'(HOLD));
        if (k >= 10)
          chk(cyc - comp_cyc >= POLL && cyc - comp_cyc <= POLL + 8, "R8 poll gap",
              32'(cyc - comp_cyc), 32'(POLL));
      end
      if (psel && penable) begin
        pready = (acc >= ws);
        acc++;
        if (pready) begin
          if (k < 6) begin
            chk(pwrite && paddr == 16'(4 * k) && pwdata == tbl_data(k), "R3 table write",
                {paddr, pwdata[15:0]}, {16'(4 * k), tbl_data(k)[15:0]});
            chk(!init_done, "R5 done low during table", 32'(init_done), 32'h0);
          end else if (k < 9) begin
            chk(pwrite && paddr == 16'h40 && pwdata == 32'(k - 5), "R6 lock step",
                {paddr, pwdata[15:0]}, {16'h40, 16'(k - 5)});
            chk(init_done, "R5 done stays high", 32'(init_done), 32'h1);
          end else begin
            chk(!pwrite && paddr == 16'h44, "R8 status read", {15'd0, pwrite, paddr},
                32'h44);
            prdata = rd_val(reads);
            last_rd = prdata;
            reads++;
            stat_cd = 3;
          end
          comp_cyc = cyc;
          k++;
        end
      end else begin
        acc = 0;
        pready = 1'b0;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 60000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
    summary();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!psel && !penable, "R1 bus idle in reset", {psel, penable}, 32'h0);
    chk(!init_done, "R1 init_done cleared / R10", 32'(init_done), 32'h0);
    chk(lane_rst == '1, "R1 lanes in reset", 32'(lane_rst), 32'hF);
    chk(status_word == '0 && !rx_locked, "R1 status cleared", status_word, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(lane_rst == '1 && !psel, "R4 settle window", 32'(lane_rst), 32'hF);
  endtask

  task automatic wait_k(input int target);
    int t = 0;
    while (k < target && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(k >= target, "R8 sequence progress", 32'(k), 32'(target));
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin
      ws = w;
      do_reset();
      wait_k(13);
    end
    // R10: reset while the table is being written
    ws = 1;
    do_reset();
    wait_k(3);
    do_reset();
    wait_k(10);
    summary();
  end

endmodule